// File: doc/BRIEF.md
# Restoring Sequential Divider

This block divides one unsigned WIDTH-bit operand by another over several clock cycles, using the restoring method. When the block is idle, a one-cycle `start` pulse captures the dividend and the divisor. The block then runs WIDTH iterations. Each iteration has three clock cycles:

- The remainder:quotient pair is shifted left by one bit.
- The divisor is subtracted from the partial remainder in a trial subtraction.
- The sign of that difference is tested. A negative difference is undone by adding the divisor back, and the new quotient bit is 0. A non-negative difference is kept, and the new quotient bit is 1.

The partial remainder is one bit wider than the operands, so the sign of the trial difference can be seen.

A zero divisor does not start any iteration. It raises a flag and finishes at once.

`done` pulses for one cycle when a result is ready. The quotient and remainder outputs hold their values until the next accepted `start`. `busy` marks the cycles in which a new `start` is ignored.

Top module: `restore_divider`

## Requirements
- R1: For a nonzero divisor, when `done` pulses, `quotient` equals the dividend divided by the divisor, rounded down.
- R2: For a nonzero divisor, when `done` pulses, `remainder` equals dividend minus quotient times divisor, and it is strictly less than the divisor.
- R3: For a nonzero divisor, `done` is high for exactly one cycle, and `busy` is high during the wait. Counting the edge that samples `start` as cycle 1, the `done` pulse is seen after clock edge number 3*WIDTH+1.
- R4: After each quotient-bit decision, the partial remainder is non-negative. A negative trial difference is always restored.
- R5: A zero divisor gives the following results:
  - `divZero` goes to 1.
  - `quotient` becomes all ones.
  - `remainder` equals the dividend.
  - `done` pulses right after the edge that samples `start`, and `busy` stays low.
- R6: `divZero` is cleared by the next accepted `start` that has a nonzero divisor.
- R7: A `start` pulse while `busy` is high has no effect on the running division or on its result.
- R8: While the block is not busy and no `start` is present, `quotient` and `remainder` keep their values.
- R9: After reset, `busy`, `done` and `divZero` are 0, and `quotient` and `remainder` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division (accepted when `busy` is low) |
| dividend | input | WIDTH | Dividend sampled with `start` |
| divisor | input | WIDTH | Divisor sampled with `start` |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle result-ready pulse |
| divZero | output | 1 | Last accepted division had a zero divisor |
| quotient | output | WIDTH | Quotient |
| remainder | output | WIDTH | Remainder |

## Verification
The assertions check four things on every cycle:
- Each restore step leaves the partial remainder non-negative and below the divisor.
- The iteration counter stays in range.
- `done` is a single-cycle pulse.
- A zero divisor finishes without going busy.

They also check that a `start` while busy never drops the block out of its run, and that idle outputs hold still.

Some behaviour only the bench scenarios can show, by sweeping every operand pair of a small width:
- The arithmetic correctness of quotient and remainder.
- The exact latency.
- The all-ones and dividend outputs for a zero divisor.
- That a `start` injected mid-run with other operands leaves the result unchanged.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_SUB,
    ST_FIX,
    ST_DONE
  } divState_e;

  typedef struct packed {
    logic load;      // capture operands, clear remainder
    logic loadZero;  // capture zero-divisor result
    logic shift;     // shift remainder:quotient left
    logic sub;       // trial subtraction
    logic fix;       // restore-or-set quotient bit
  } divCtl_t;

endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    divisorZero,
  output divCtl_t ctl,
  output logic    busy,
  output logic    done,
  output logic    divZero
);

  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST_ITER = CW'(WIDTH - 1);

  divState_e state, stateNext;
  logic [CW-1:0] iterCnt;
  logic accept;

  assign accept = start && (state == ST_IDLE || state == ST_DONE);

  always_comb begin
    stateNext = state;
    ctl = '0;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        stateNext = ST_IDLE;
        if (accept) begin
          if (divisorZero) begin
            ctl.loadZero = 1'b1;
            stateNext = ST_DONE;
          end else begin
            ctl.load = 1'b1;
            stateNext = ST_SHIFT;
          end
        end
      end
      ST_SHIFT: begin
        ctl.shift = 1'b1;
        stateNext = ST_SUB;
      end
      ST_SUB: begin
        ctl.sub = 1'b1;
        stateNext = ST_FIX;
      end
      ST_FIX: begin
        ctl.fix = 1'b1;
        stateNext = (iterCnt == LAST_ITER) ? ST_DONE : ST_SHIFT;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      divZero <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctl.load || ctl.loadZero) iterCnt <= '0;
      else if (ctl.fix)             iterCnt <= iterCnt + 1'b1;
      if (ctl.load)          divZero <= 1'b0;
      else if (ctl.loadZero) divZero <= 1'b1;
    end
  end

  assign busy = (state == ST_SHIFT) || (state == ST_SUB) || (state == ST_FIX);
  assign done = (state == ST_DONE);

  assert_iter_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (iterCnt < CW'(WIDTH)));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_zero_fast_R5: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && divisorZero) |=> (done && !busy && divZero));

endmodule

// File: rtl/div_datapath.sv
module div_datapath
  import div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  divCtl_t          ctl,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             divisorZero,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  localparam int AW = WIDTH + 1;

  logic [AW-1:0]    aReg;
  logic [WIDTH-1:0] qReg;
  logic [WIDTH-1:0] mReg;
  logic [AW-1:0]    mWide;
  logic [AW-1:0]    diff;
  logic [AW-1:0]    restored;

  assign mWide    = {1'b0, mReg};
  assign diff     = aReg - mWide;
  assign restored = aReg + mWide;
  assign divisorZero = (divisor == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg <= '0;
      qReg <= '0;
      mReg <= '0;
    end else begin
      if (ctl.load) begin
        aReg <= '0;
        qReg <= dividend;
        mReg <= divisor;
      end else if (ctl.loadZero) begin
        aReg <= {1'b0, dividend};
        qReg <= '1;
        mReg <= '0;
      end else if (ctl.shift) begin
        {aReg, qReg} <= {aReg[AW-2:0], qReg, 1'b0};
      end else if (ctl.sub) begin
        aReg <= diff;
      end else if (ctl.fix) begin
        if (aReg[AW-1]) begin
          aReg    <= restored;
          qReg[0] <= 1'b0;
        end else begin
          qReg[0] <= 1'b1;
        end
      end
    end
  end

  assign quotient  = qReg;
  assign remainder = aReg[WIDTH-1:0];

  assert_restore_sign_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fix |=> !aReg[AW-1]);

  assert_rem_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fix && mReg != '0) |=> (aReg < mWide));

endmodule

// File: rtl/restore_divider.sv
module restore_divider
  import div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic             divZero,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);

  divCtl_t ctl;
  logic divisorZero;

  div_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .divisorZero(divisorZero),
    .ctl(ctl), .busy(busy), .done(done), .divZero(divZero)
  );

  div_datapath #(.WIDTH(WIDTH)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dividend(dividend), .divisor(divisor),
    .divisorZero(divisorZero), .quotient(quotient), .remainder(remainder)
  );

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy) |=> (busy || done));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder)));

endmodule

// File: tb/restore_divider_tb_top.sv
module restore_divider_tb_top;

  localparam int W = 5;
  localparam int CLK_PERIOD = 10;
  localparam int MAXV = (1 << W);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic busy, done, divZero;
  logic [W-1:0] quotient, remainder;

  int testCnt = 0;
  int failCnt = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  restore_divider #(.WIDTH(W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .divZero(divZero), .quotient(quotient), .remainder(remainder)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runOp(input int a, input int b, input bit poke);
    int cycles;
    int expQ, expR, expLat;
    int q0, r0;
    @(negedge clk);
    dividend = W'(a);
    divisor  = W'(b);
    start = 1'b1;
    @(posedge clk);
    cycles = 1;
    @(negedge clk);
    start = 1'b0;
    if (b == 0) check(busy == 1'b0, "R5 busy", busy, 0);
    else        check(busy == 1'b1, "R3 busy", busy, 1);
    while (!done && cycles < 500) begin
      if (poke && cycles == 2) begin
        start = 1'b1;
        dividend = W'(~a);
        divisor  = W'(b + 1);
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      cycles++;
      @(negedge clk);
    end
    start = 1'b0;
    if (b == 0) begin
      expQ = MAXV - 1;
      expR = a;
      expLat = 1;
      check(divZero == 1'b1, "R5 divZero", divZero, 1);
      check(quotient == W'(expQ), "R5 quotient", quotient, expQ);
      check(remainder == W'(expR), "R5 remainder", remainder, expR);
      check(cycles == expLat, "R5 latency", cycles, expLat);
    end else begin
      expQ = a / b;
      expR = a % b;
      expLat = 3 * W + 1;
      check(divZero == 1'b0, "R6 divZero", divZero, 0);
      check(quotient == W'(expQ), poke ? "R7 quotient" : "R1 quotient", quotient, expQ);
      check(remainder == W'(expR), poke ? "R7 remainder" : "R2 remainder", remainder, expR);
      check(int'(quotient) * b + int'(remainder) == a && int'(remainder) < b,
            "R2 identity", int'(quotient) * b + int'(remainder), a);
      check(cycles == expLat, "R3 latency", cycles, expLat);
    end
    q0 = quotient;
    r0 = remainder;
    @(negedge clk);
    check(done == 1'b0, "R3 done pulse", done, 0);
    @(negedge clk);
    check(quotient == W'(q0) && remainder == W'(r0), "R8 hold", quotient, q0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failCnt++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset values
    check(busy == 0 && done == 0 && divZero == 0, "R9 flags", {busy, done, divZero}, 0);
    check(quotient == 0 && remainder == 0, "R9 data", quotient, 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int a = 0; a < MAXV; a++) begin
      for (int b = 0; b < MAXV; b++) begin
        runOp(a, b, ((a + b) % 7) == 0);
      end
    end
    // R6: flag set then cleared by a nonzero divisor
    runOp(9, 0, 1'b0);
    runOp(9, 4, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule